// File: doc/BRIEF.md
# Framed Two-Pattern Serial Recognizer

This block watches a serial bit stream one qualified bit at a time. It cuts the stream into back-to-back groups of four valid bits. On the last bit of each group it raises its output for that cycle when the group, oldest bit first, reads 0101 or 1001. After every fourth valid bit the machine goes back to its start state, whatever it has seen, so groups never share bits. Other four-bit groups produce no pulse.

The controller is a reduced state machine with seven states. Both accepting prefixes, 01 and 10, lead into one shared state. Every prefix that can no longer match falls into a common reject chain, which only counts out the rest of the group. The output is a Mealy term: it is high when the machine is in its last-bit state, the current bit is 1 and the bit is valid. A parameter picks the state register encoding when the block is elaborated. The compact form uses three flip-flops and codes the start state as all zeros. The one-hot form uses one flip-flop per state.

Top module: `frame_pair_detect`

## Requirements
- R1: `z` is 1 in the cycle that carries the fourth valid bit of a group exactly when the group's bits, in arrival order, are 0101 or 1001. Every other group gives 0 on its fourth bit.
- R2: After every fourth valid bit the machine is back at the start of a group, whatever the bits were. A pattern that spans two groups is never reported.
- R3: `z` is 0 on the first, second and third valid bits of every group.
- R4: When `vld` is 0, `z` is 0 and the bit on `x` is ignored. Frame position and history hold, so a group can be split by any number of idle cycles.
- R5: While `rst` is 1 at a rising edge (synchronous, active high), the machine moves to the start of a group. This also discards a partly received group.
- R6: With `ONE_HOT` = 0 the state register is 3 bits and the start state is 000. With `ONE_HOT` = 1 it is 7 bits, reset sets only the start bit, and exactly one bit is set at all times. Both encodings give identical `z`.
- R7: The input groups 0101, 0010, 1001, 0100 give the outputs 0001, 0000, 0001, 0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to group start |
| vld | input | 1 | Qualifies `x` in this cycle |
| x | input | 1 | Serial input bit |
| z | output | 1 | Match pulse on the last bit of an accepted group |

## Verification
The hardest case to reach from the ports is the machine sitting in its last-bit state while `vld` is low and `x` is 1. An encoding that does not gate the output with `vld` would pulse here. The stimulus builds the prefix 010 with idle cycles in between and drives `x` high during those gaps. It also places resets in the middle of a group, including one that lands in the last-bit state. Long random streams with random idle cycles are run against a model that slices the stream into four-bit groups. About a third of the groups in those streams are forced to be an accepted pattern, so matches come often.

// File: rtl/frame_pair_detect.sv
module frame_pair_detect #(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic vld,
  input  logic x,
  output logic z
);
  localparam int SW = ONE_HOT ? 7 : 3;
  localparam logic [SW-1:0] RST_VAL = ONE_HOT ? SW'(1) : '0;

  logic [SW-1:0] st_q, st_d;
  logic in_last, at_start;

  generate
    if (!ONE_HOT) begin : g_bin
      always_comb begin
        case (st_q)
          3'd0:    st_d = x ? 3'd2 : 3'd1;
          3'd1:    st_d = x ? 3'd3 : 3'd4;
          3'd2:    st_d = x ? 3'd4 : 3'd3;
          3'd3:    st_d = x ? 3'd6 : 3'd5;
          3'd4:    st_d = 3'd6;
          default: st_d = 3'd0;
        endcase
      end
      assign in_last  = (st_q == 3'd5);
      assign at_start = (st_q == 3'd0);
    end else begin : g_oh
      assign st_d[0] = st_q[5] | st_q[6];
      assign st_d[1] = st_q[0] & ~x;
      assign st_d[2] = st_q[0] & x;
      assign st_d[3] = (st_q[1] & x) | (st_q[2] & ~x);
      assign st_d[4] = (st_q[1] & ~x) | (st_q[2] & x);
      assign st_d[5] = st_q[3] & ~x;
      assign st_d[6] = (st_q[3] & x) | st_q[4];
      assign in_last  = st_q[5];
      assign at_start = st_q[0];

      a_r6_one_set: assert property (@(posedge clk) disable iff (rst)
        $countones(st_q) == 1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)      st_q <= RST_VAL;
    else if (vld) st_q <= st_d;
  end

  assign z = vld & x & in_last;

  logic [1:0] pos_q;
  always_ff @(posedge clk) begin
    if (rst)      pos_q <= 2'd0;
    else if (vld) pos_q <= pos_q + 2'd1;
  end

  a_r3_z_on_fourth: assert property (@(posedge clk) disable iff (rst)
    z |-> (pos_q == 2'd3));
  a_r2_group_restart: assert property (@(posedge clk) disable iff (rst)
    (vld && pos_q == 2'd3) |=> at_start);
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !vld |=> $stable(st_q));
  a_r4_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !vld |-> !z);
  a_r1_match_needs_one: assert property (@(posedge clk) disable iff (rst)
    z |-> (x && pos_q == 2'd3));
endmodule

// File: tb/frame_pair_detect_tb_top.sv
`timescale 1ns/1ps
module frame_pair_detect_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, vld = 1'b0, x = 1'b0;
  logic z_bin, z_oh;

  frame_pair_detect #(.ONE_HOT(1'b0)) dut_i (
    .clk(clk), .rst(rst), .vld(vld), .x(x), .z(z_bin));
  frame_pair_detect #(.ONE_HOT(1'b1)) dut_oh_i (
    .clk(clk), .rst(rst), .vld(vld), .x(x), .z(z_oh));

  bit    qz[$];
  string qt[$];
  int checks = 0, fails = 0;
  bit [3:0] fb = 4'b0;
  int fn = 0;
  bit done = 1'b0;

  task automatic step(input bit v, input bit b, input string tag);
    bit e;
    @(negedge clk);
    rst = 1'b0; vld = v; x = b; e = 1'b0;
    if (v) begin
      fb = {fb[2:0], b};
      fn++;
      if (fn == 4) begin
        e  = (fb == 4'b0101) || (fb == 4'b1001);
        fn = 0;
      end
    end
    qz.push_back(e);
    qt.push_back(tag);
  endtask

  task automatic reset_cyc(input string tag);
    @(negedge clk);
    rst = 1'b1; vld = 1'b0; x = 1'b1;
    fn = 0; fb = 4'b0;
    qz.push_back(1'b0);
    qt.push_back(tag);
  endtask

  task automatic frame(input bit [3:0] bits, input string tag);
    for (int i = 3; i >= 0; i--) step(1'b1, bits[i], tag);
  endtask

  task automatic check(input logic act, input bit e, input string tag, input string enc);
    checks++;
    if (act !== e) begin
      fails++;
      $display("FAIL %s (%s encoding) t=%0t: z actual=%b expected=%b", tag, enc, $time, act, e);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (qz.size() > 0) begin
        bit e;
        string t;
        e = qz.pop_front();
        t = qt.pop_front();
        check(z_bin, e, t, "binary");
        check(z_oh, e, t, "one-hot");
      end
    end
  end

  initial begin
    reset_cyc("R5 reset state");
    reset_cyc("R5 reset state");
    step(1'b0, 1'b1, "R4 idle after reset");
    // R7 worked example
    frame(4'b0101, "R7"); frame(4'b0010, "R7");
    frame(4'b1001, "R7"); frame(4'b0100, "R7");
    // R1 / R3: every group value
    for (int p = 0; p < 16; p++) frame(4'(p), "R1 R3 exhaustive");
    // R2: patterns across group boundaries must not fire
    frame(4'b0010, "R2"); frame(4'b1010, "R2"); frame(4'b0110, "R2");
    frame(4'b0101, "R2"); frame(4'b1100, "R2"); frame(4'b1001, "R2");
    // R4: idle cycles inside a group, x high in the last-bit state
    step(1'b1, 1'b0, "R4"); step(1'b0, 1'b1, "R4");
    step(1'b1, 1'b1, "R4"); step(1'b0, 1'b0, "R4");
    step(1'b1, 1'b0, "R4"); step(1'b0, 1'b1, "R4");
    step(1'b0, 1'b1, "R4"); step(1'b1, 1'b1, "R4");
    // R5: reset mid-group, then in the last-bit state
    step(1'b1, 1'b1, "R5"); step(1'b1, 1'b0, "R5");
    reset_cyc("R5 mid-group");
    frame(4'b0101, "R5 after reset");
    step(1'b1, 1'b1, "R5"); step(1'b1, 1'b0, "R5"); step(1'b1, 1'b0, "R5");
    reset_cyc("R5 last-bit state");
    frame(4'b1001, "R5 after reset");
    // R6 / R1: random streams through both encodings
    for (int k = 0; k < 500; k++) begin
      if ($urandom_range(0, 2) == 0 && fn == 0) begin
        bit [3:0] pat;
        pat = $urandom_range(0, 1) ? 4'b0101 : 4'b1001;
        for (int i = 3; i >= 0; i--) begin
          if ($urandom_range(0, 3) == 0) step(1'b0, 1'($urandom_range(0, 1)), "R6 random idle");
          step(1'b1, pat[i], "R6 R1 random");
        end
      end else begin
        step($urandom_range(0, 3) != 0, 1'($urandom_range(0, 1)), "R6 R1 random");
      end
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(50000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule